// File: doc/BRIEF.md
# Scoreboard Dynamic-Scheduling Controller

This block is a centralized scoreboard. It accepts at most one decoded instruction per cycle and issues instructions strictly in program order. Operand reads, execution and result write-back then proceed out of order as dependencies resolve. Each decoded instruction carries a unit class, a destination register and two source registers. The block keeps a per-unit status table and a per-register table recording which unit will produce each register. From these tables it decides, every cycle:

- whether the presented instruction issues;
- which waiting units may read their operands;
- which finished unit may write its result.

The functional units are modelled as latency counters, so no arithmetic is performed. There is no forwarding and no renaming. Write-after-write conflicts are resolved by stalling at issue. Write-after-read conflicts are resolved by holding the finished unit at write-back.

A fetch stage presents an instruction and holds it while `issue_stall` is high. The per-unit phase, read-grant and write-grant outputs expose the whole schedule, so it can be compared cycle by cycle against an expected timeline.

Top module: `sb_core`

## Requirements
- R1: After reset every unit reports phase 0 (idle), no unit is busy, and no read or write grant is raised.
- R2: Units and unit ids are fixed as follows. Class code 0 (integer) maps to unit id 1. Class code 1 (multiply) maps to ids 2 and 3, and the lowest free id is taken first. Class code 2 (add) maps to id 4. Class code 3 (divide) maps to id 5. An instruction issues only when a unit of its class is idle. Otherwise `issue_stall` is high, and the held instruction and all later ones wait.
- R3: An instruction whose destination register still has a pending producer does not issue until the cycle after that producer writes its result.
- R4: A source whose producer is still active blocks the read grant. The read grant comes in the cycle after the producer's write, and never earlier.
- R5: A unit whose sources have no pending producer at issue receives its read grant in the cycle after issue.
- R6: A unit requests write-back L+1 cycles after its read grant. L is 1 for integer, 10 for multiply, 2 for add and 40 for divide.
- R7: A finished unit is held at write-back while any other unit waits to read a register equal to its destination and that source is marked ready. It writes in the cycle after that reader's grant.
- R8: At most one unit writes per cycle. When several units are eligible, the lowest unit id writes and the others wait.
- R9: The phase output per unit uses 2 bits at bit offset 2×(id−1): 0 idle, 1 waiting for operands, 2 executing, 3 waiting to write. The busy output is high exactly when the phase is non-zero.
- R10: A unit that writes is idle in the next cycle and can accept a new instruction in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_cls | input | 2 | Unit class: 0 integer, 1 multiply, 2 add, 3 divide |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| issue_stall | output | 1 | Presented instruction cannot issue this cycle |
| issue_fire | output | 1 | Presented instruction issues at this clock edge |
| issue_unit | output | 3 | Unit id receiving the issue, 0 when none |
| unit_busy | output | 5 | Per-unit busy, bit id−1 |
| unit_phase | output | 10 | Per-unit phase, 2 bits per unit |
| rd_fire | output | 5 | Per-unit operand-read grant this cycle |
| wb_fire | output | 5 | Per-unit write-back grant this cycle |

## Verification
The schedule is tried with several instruction patterns, and each one isolates a single hazard rule:

- A lone instruction measures the issue-to-read and read-to-write latency.
- Back-to-back integer operations expose the structural stall and the reuse of a freed unit.
- A multiply followed by an add to the same destination separates the WAW stall at issue from a RAW wait.
- A dependent add reading a long multiply result, together with an integer op overwriting the add's other source, distinguishes the WAR hold at write-back from the RAW hold at read.
- Two multiplies and an add timed to finish together show the priority order of write-back.
- A divide followed by a second divide confirms the longest latency and the issue block behind it.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int REG_W  = 5;
    localparam int NREG   = 1 << REG_W;
    localparam int UID_W  = 3;

    typedef enum logic [1:0] {
        CL_INT = 2'd0,
        CL_MUL = 2'd1,
        CL_ADD = 2'd2,
        CL_DIV = 2'd3
    } fu_class_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPS  = 2'd1,
        PH_EXEC = 2'd2,
        PH_WB   = 2'd3
    } fu_phase_t;

    typedef struct packed {
        fu_class_t              op;
        logic [REG_W-1:0]       fi;
        logic [REG_W-1:0]       fj;
        logic [REG_W-1:0]       fk;
        logic [UID_W-1:0]       qj;
        logic [UID_W-1:0]       qk;
        logic                   rj;
        logic                   rk;
    } fu_stat_t;

    // Class served by unit slot idx (slot = id - 1)
    function automatic fu_class_t class_of(input int idx, input int nmul);
        if (idx == 0)
            return CL_INT;
        else if (idx <= nmul)
            return CL_MUL;
        else if (idx == nmul + 1)
            return CL_ADD;
        else
            return CL_DIV;
    endfunction

endpackage

// File: rtl/sb_unit_ctrl.sv
module sb_unit_ctrl
    import sb_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      go,
    input  logic      wr,
    output fu_phase_t phase
);
    localparam int CW = (LAT > 1) ? $clog2(LAT + 1) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) phase <= PH_OPS;
                PH_OPS: if (go) begin
                    phase <= PH_EXEC;
                    cnt   <= CW'(LAT - 1);
                end
                PH_EXEC: begin
                    if (cnt == '0) phase <= PH_WB;
                    else           cnt   <= cnt - 1'b1;
                end
                PH_WB: if (wr) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sb_issue_sel.sv
module sb_issue_sel
    import sb_pkg::*;
#(
    parameter int NFU     = 5,
    parameter int NUM_MUL = 2
) (
    input  fu_class_t          cls,
    input  logic [NFU-1:0]     busy,
    output logic               found,
    output logic [UID_W-1:0]   sel_id
);
    always_comb begin
        found  = 1'b0;
        sel_id = '0;
        for (int i = NFU - 1; i >= 0; i--) begin
            if (class_of(i, NUM_MUL) == cls && !busy[i]) begin
                found  = 1'b1;
                sel_id = UID_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb
    import sb_pkg::*;
#(
    parameter int NFU = 5
) (
    input  fu_stat_t [NFU-1:0] tab,
    input  logic [NFU-1:0]     waiting_ops,
    input  logic [NFU-1:0]     want,
    output logic [NFU-1:0]     grant,
    output logic               any,
    output logic [UID_W-1:0]   win_id,
    output logic [REG_W-1:0]   win_reg
);
    logic [NFU-1:0] war;
    logic [NFU-1:0] ok;

    always_comb begin
        for (int i = 0; i < NFU; i++) begin
            war[i] = 1'b0;
            for (int f = 0; f < NFU; f++) begin
                if (f != i && waiting_ops[f] &&
                    ((tab[f].fj == tab[i].fi && tab[f].rj) ||
                     (tab[f].fk == tab[i].fi && tab[f].rk)))
                    war[i] = 1'b1;
            end
        end
        ok = want & ~war;
    end

    always_comb begin
        grant   = '0;
        any     = 1'b0;
        win_id  = '0;
        win_reg = '0;
        for (int i = NFU - 1; i >= 0; i--) begin
            if (ok[i]) begin
                grant   = '0;
                grant[i] = 1'b1;
                any     = 1'b1;
                win_id  = UID_W'(i + 1);
                win_reg = tab[i].fi;
            end
        end
    end
endmodule

// File: rtl/sb_core.sv
module sb_core
    import sb_pkg::*;
#(
    parameter int NUM_MUL = 2,
    parameter int LAT_INT = 1,
    parameter int LAT_MUL = 10,
    parameter int LAT_ADD = 2,
    parameter int LAT_DIV = 40,
    parameter int NFU     = NUM_MUL + 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0]         in_cls,
    input  logic [REG_W-1:0]   in_dst,
    input  logic [REG_W-1:0]   in_src1,
    input  logic [REG_W-1:0]   in_src2,
    output logic               issue_stall,
    output logic               issue_fire,
    output logic [UID_W-1:0]   issue_unit,
    output logic [NFU-1:0]     unit_busy,
    output logic [2*NFU-1:0]   unit_phase,
    output logic [NFU-1:0]     rd_fire,
    output logic [NFU-1:0]     wb_fire
);
    fu_stat_t [NFU-1:0]  tab;
    logic [UID_W-1:0]    owner [NREG];
    fu_phase_t           ph [NFU];
    logic [NFU-1:0]      waiting_ops;
    logic [NFU-1:0]      want_wb;

    logic                found;
    logic [UID_W-1:0]    sel_id;
    logic                waw;
    logic                any_wb;
    logic [UID_W-1:0]    wb_id;
    logic [REG_W-1:0]    wb_reg;
    logic [UID_W-1:0]    q1, q2;

    // Per-unit phase machines
    for (genvar g = 0; g < NFU; g++) begin : g_unit
        localparam int L = (g == 0)           ? LAT_INT :
                           (g <= NUM_MUL)     ? LAT_MUL :
                           (g == NUM_MUL + 1) ? LAT_ADD : LAT_DIV;
        sb_unit_ctrl #(.LAT(L)) u_ctrl (
            .clk   (clk),
            .rst   (rst),
            .start (issue_fire && sel_id == UID_W'(g + 1)),
            .go    (rd_fire[g]),
            .wr    (wb_fire[g]),
            .phase (ph[g])
        );
        assign unit_busy[g]          = (ph[g] != PH_IDLE);
        assign unit_phase[2*g +: 2]  = ph[g];
        assign waiting_ops[g]        = (ph[g] == PH_OPS);
        assign want_wb[g]            = (ph[g] == PH_WB);
        assign rd_fire[g]            = waiting_ops[g] && tab[g].rj && tab[g].rk;
    end

    sb_issue_sel #(.NFU(NFU), .NUM_MUL(NUM_MUL)) u_sel (
        .cls    (fu_class_t'(in_cls)),
        .busy   (unit_busy),
        .found  (found),
        .sel_id (sel_id)
    );

    sb_wb_arb #(.NFU(NFU)) u_arb (
        .tab         (tab),
        .waiting_ops (waiting_ops),
        .want        (want_wb),
        .grant       (wb_fire),
        .any         (any_wb),
        .win_id      (wb_id),
        .win_reg     (wb_reg)
    );

    // Issue decision: structural and WAW checks
    always_comb begin
        waw         = (owner[in_dst] != '0);
        issue_fire  = in_valid && found && !waw;
        issue_stall = in_valid && !issue_fire;
        issue_unit  = issue_fire ? sel_id : '0;
        // A producer writing in this very cycle no longer counts as pending
        q1 = owner[in_src1];
        q2 = owner[in_src2];
        if (any_wb && q1 == wb_id) q1 = '0;
        if (any_wb && q2 == wb_id) q2 = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tab <= '0;
            for (int r = 0; r < NREG; r++) owner[r] <= '0;
        end else begin
            for (int i = 0; i < NFU; i++) begin
                if (rd_fire[i]) begin
                    tab[i].rj <= 1'b0;
                    tab[i].rk <= 1'b0;
                    tab[i].qj <= '0;
                    tab[i].qk <= '0;
                end else if (any_wb) begin
                    if (tab[i].qj == wb_id) begin
                        tab[i].rj <= 1'b1;
                        tab[i].qj <= '0;
                    end
                    if (tab[i].qk == wb_id) begin
                        tab[i].rk <= 1'b1;
                        tab[i].qk <= '0;
                    end
                end
            end
            if (any_wb)
                owner[wb_reg] <= '0;
            if (issue_fire) begin
                tab[sel_id - 1'b1] <= '{op: fu_class_t'(in_cls), fi: in_dst,
                                        fj: in_src1, fk: in_src2,
                                        qj: q1, qk: q2,
                                        rj: (q1 == '0), rk: (q2 == '0)};
                owner[in_dst] <= sel_id;
            end
        end
    end
endmodule

// File: rtl/sb_core_chk.sv
module sb_core_chk
    import sb_pkg::*;
#(
    parameter int NFU = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             issue_fire,
    input logic [UID_W-1:0] issue_unit,
    input logic [NFU-1:0]   unit_busy,
    input logic [2*NFU-1:0] unit_phase,
    input logic [NFU-1:0]   rd_fire,
    input logic [NFU-1:0]   wb_fire
);
    p_single_write_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wb_fire));

    for (genvar g = 0; g < NFU; g++) begin : g_chk
        p_read_from_wait_r5: assert property (@(posedge clk) disable iff (rst)
            rd_fire[g] |-> unit_phase[2*g +: 2] == 2'd1);
        p_exec_after_read_r6: assert property (@(posedge clk) disable iff (rst)
            rd_fire[g] |=> unit_phase[2*g +: 2] == 2'd2);
        p_write_from_wait_r7: assert property (@(posedge clk) disable iff (rst)
            wb_fire[g] |-> unit_phase[2*g +: 2] == 2'd3);
        p_free_after_write_r10: assert property (@(posedge clk) disable iff (rst)
            wb_fire[g] |=> !unit_busy[g]);
        p_issue_claims_idle_r2: assert property (@(posedge clk) disable iff (rst)
            (issue_fire && issue_unit == UID_W'(g + 1)) |-> !unit_busy[g]);
        p_issue_enters_wait_r9: assert property (@(posedge clk) disable iff (rst)
            (issue_fire && issue_unit == UID_W'(g + 1)) |=> unit_phase[2*g +: 2] == 2'd1);
    end
endmodule

bind sb_core sb_core_chk #(.NFU(NFU)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .issue_fire (issue_fire),
    .issue_unit (issue_unit),
    .unit_busy  (unit_busy),
    .unit_phase (unit_phase),
    .rd_fire    (rd_fire),
    .wb_fire    (wb_fire)
);

// File: tb/sim_sb_core.sv
module sim_sb_core;
    localparam int CLK_PERIOD = 10;
    localparam int NFU = 5;
    localparam int NCYC = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [1:0] in_cls = '0;
    logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic issue_stall, issue_fire;
    logic [2:0] issue_unit;
    logic [NFU-1:0] unit_busy, rd_fire, wb_fire;
    logic [2*NFU-1:0] unit_phase;

    sb_core u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .issue_stall(issue_stall), .issue_fire(issue_fire), .issue_unit(issue_unit),
        .unit_busy(unit_busy), .unit_phase(unit_phase),
        .rd_fire(rd_fire), .wb_fire(wb_fire)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // instruction queue
    int q_n;
    int q_cls [8];
    int q_dst [8];
    int q_s1 [8];
    int q_s2 [8];
    int q_start [8];
    int head;

    // event logs
    int iss_cyc [8];
    int iss_uid [8];
    int rd_at [8];
    int wb_at [8];
    int stall_cnt;
    logic [2*NFU-1:0] ph_at [NCYC];
    logic [NFU-1:0] busy0, rd0, wb0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic q_clear();
        q_n = 0;
    endtask

    task automatic q_add(input int c, input int d, input int s1, input int s2, input int st);
        q_cls[q_n] = c; q_dst[q_n] = d; q_s1[q_n] = s1; q_s2[q_n] = s2;
        q_start[q_n] = st;
        q_n++;
    endtask

    function automatic int ph_of(input int c, input int uid);
        return int'(ph_at[c][2*(uid-1) +: 2]);
    endfunction

    task automatic run_scn();
        rst = 1'b1;
        in_valid = 1'b0;
        head = 0;
        stall_cnt = 0;
        for (int k = 0; k < 8; k++) begin
            iss_cyc[k] = -1; iss_uid[k] = -1; rd_at[k] = -1; wb_at[k] = -1;
        end
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        for (int c = 0; c < NCYC; c++) begin
            if (head < q_n && c >= q_start[head]) begin
                in_valid = 1'b1;
                in_cls   = 2'(q_cls[head]);
                in_dst   = 5'(q_dst[head]);
                in_src1  = 5'(q_s1[head]);
                in_src2  = 5'(q_s2[head]);
            end else begin
                in_valid = 1'b0;
            end
            #5;
            ph_at[c] = unit_phase;
            if (c == 0) begin
                busy0 = unit_busy; rd0 = rd_fire; wb0 = wb_fire;
            end
            if (issue_stall) stall_cnt++;
            for (int u = 0; u < NFU; u++) begin
                if (rd_fire[u]) rd_at[u+1] = c;
                if (wb_fire[u]) wb_at[u+1] = c;
            end
            if (issue_fire) begin
                iss_cyc[head] = c;
                iss_uid[head] = int'(issue_unit);
                head++;
            end
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        // Scenario A: lone integer op
        q_clear(); q_add(0, 3, 1, 2, 0);
        run_scn();
        chk("R1 busy at start", int'(busy0), 0);
        chk("R1 read grants at start", int'(rd0), 0);
        chk("R1 write grants at start", int'(wb0), 0);
        chk("R1 phase at start", int'(ph_at[0]), 0);
        chk("R2 integer unit id", iss_uid[0], 1);
        chk("R5 read after issue", rd_at[1], 1);
        chk("R6 integer write", wb_at[1], 3);
        chk("R9 phase waiting ops", ph_of(1, 1), 1);
        chk("R9 phase executing", ph_of(2, 1), 2);
        chk("R9 phase waiting write", ph_of(3, 1), 3);
        chk("R10 idle after write", ph_of(4, 1), 0);

        // Scenario B: RAW through register 2
        q_clear(); q_add(0, 2, 1, 1, 0); q_add(2, 4, 2, 2, 1);
        run_scn();
        chk("R2 add unit id", iss_uid[1], 4);
        chk("R4 add issue not blocked", iss_cyc[1], 1);
        chk("R4 add waits for producer", ph_of(3, 4), 1);
        chk("R4 add read after write", rd_at[4], 4);
        chk("R6 add write", wb_at[4], 7);

        // Scenario C: structural hazard on integer unit
        q_clear(); q_add(0, 5, 1, 1, 0); q_add(0, 6, 1, 1, 0);
        run_scn();
        chk("R2 structural stall cycles", stall_cnt, 3);
        chk("R10 reuse after write", iss_cyc[1], 4);

        // Scenario D: WAW on register 6
        q_clear(); q_add(1, 6, 1, 1, 0); q_add(2, 6, 1, 1, 1);
        run_scn();
        chk("R6 multiply write", wb_at[2], 12);
        chk("R3 waw issue delay", iss_cyc[1], 13);
        chk("R3 waw stall cycles", stall_cnt, 12);

        // Scenario E: WAR on register 8
        q_clear(); q_add(1, 0, 1, 1, 0); q_add(2, 10, 0, 8, 1); q_add(0, 8, 3, 3, 2);
        run_scn();
        chk("R4 add read after multiply", rd_at[4], 13);
        chk("R7 integer held at write", ph_of(10, 1), 3);
        chk("R7 integer write after reader", wb_at[1], 14);
        chk("R6 add write after read", wb_at[4], 16);

        // Scenario F: simultaneous completions
        q_clear(); q_add(1, 5, 1, 1, 0); q_add(1, 7, 1, 1, 1); q_add(2, 9, 1, 1, 8);
        run_scn();
        chk("R2 second multiplier id", iss_uid[1], 3);
        chk("R8 first multiplier write", wb_at[2], 12);
        chk("R8 second multiplier write", wb_at[3], 13);
        chk("R8 add waits lower ids", wb_at[4], 14);

        // Scenario G: divide latency and issue block
        q_clear(); q_add(3, 1, 2, 3, 0); q_add(0, 11, 4, 4, 1); q_add(3, 12, 4, 4, 2);
        run_scn();
        chk("R2 divide unit id", iss_uid[0], 5);
        chk("R6 divide write", wb_at[5], 42);
        chk("R6 integer write under divide", wb_at[1], 4);
        chk("R2 second divide held", iss_cyc[2], 43);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule